// File: doc/BRIEF.md
# Parallel Reduction Tree with Identity

This block collapses an array of `N` elements, each `W` bits wide, into one element in a single combinational pass. It does this with a balanced binary tree of two-input operator nodes. The operator is picked at elaboration from a small set: wrapping add, unsigned maximum, AND, OR and XOR. The caller supplies the data array and an identity element on the same inputs, and reads the reduced value on the output.

The tree is sized to the next power of two at or above `N`, so `N` may be any positive count. Leaves beyond the `N` real elements take the identity element from its input port. The identity is never a constant inside the block. The caller therefore chooses it to match the operator: zero for add, OR, XOR and max, and all ones for AND. With that choice the output equals a plain left-to-right fold over the elements.

The block holds no state. Its state-machine view has a single state, EVAL, with one transition: EVAL to EVAL on any input change, and the output settles within that same cycle.

Top module: `par_reduce`

## Requirements
- R1: The output depends only on the present inputs. A change of `data_i` or `ident_i` reaches `result_o` without any clock edge.
- R2: With `OP = OP_ADD` and a zero identity, `result_o` is the sum of the `N` elements modulo 2^W.
- R3: With `OP = OP_MAX` and a zero identity, `result_o` is the largest element under unsigned comparison, so it is at least every element.
- R4: With `OP = OP_AND` and an all-ones identity, `result_o` is the bitwise AND of all elements. No result bit is set that is clear in any element.
- R5: With `OP = OP_OR` and a zero identity, `result_o` is the bitwise OR of all elements. Every bit set in any element is set in the result.
- R6: With `OP = OP_XOR` and a zero identity, `result_o` is the bitwise XOR of all elements.
- R7: When `N = 1`, `result_o` equals the single element for any identity value.
- R8: When `N` is not a power of two, exactly `2^ceil(log2 N) - N` leaves carry `ident_i`. The result is then the fold of the elements followed by that many further applications of the operator with `ident_i`, so a wrong identity shows up in the output.
- R9: When `N` is a power of two, `ident_i` has no effect on `result_o`.
- R10: Element k of the array occupies bits `[k*W +: W]` of `data_i`, with element 0 at the least significant end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N*W | Packed element array, element k at bits k*W upward |
| ident_i | input | W | Identity element used to fill unused tree leaves |
| result_o | output | W | Reduced value of the whole array |

## Verification
Several tree shapes are driven from one shared element array: 13 elements with add and with XOR, 3 with max, 5 with AND, 8 with OR, and 1 as a pass-through. All-zero and all-ones arrays test the extreme values. Random arrays paired with the correct identity test the fold itself. Random arrays paired with a random identity show whether padding uses exactly the expected number of identity leaves, or, for the power-of-two and single-element shapes, whether the identity is ignored. A single set element moved across positions catches a wrong slice order, and a mid-cycle input change with no clock edge shows that no register sits in the path.

// File: rtl/par_reduce_pkg.sv
package par_reduce_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_MAX = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } op_e;
endpackage

// File: rtl/reduce_node.sv
module reduce_node #(
    parameter int W = 8,
    parameter par_reduce_pkg::op_e OP = par_reduce_pkg::OP_ADD
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    import par_reduce_pkg::*;

    // one operator variant is elaborated per parameter value
    generate
        if (OP == OP_ADD) begin : g_add
            assign y_o = a_i + b_i;
        end else if (OP == OP_MAX) begin : g_max
            assign y_o = (a_i > b_i) ? a_i : b_i;
        end else if (OP == OP_AND) begin : g_and
            assign y_o = a_i & b_i;
        end else if (OP == OP_OR) begin : g_or
            assign y_o = a_i | b_i;
        end else begin : g_xor
            assign y_o = a_i ^ b_i;
        end
    endgenerate
endmodule

// File: rtl/reduce_pad.sv
module reduce_pad #(
    parameter int W      = 8,
    parameter int N      = 13,
    parameter int LEAVES = 16
) (
    input  logic [N*W-1:0]      data_i,
    input  logic [W-1:0]        ident_i,
    output logic [LEAVES*W-1:0] leaves_o
);
    // real elements fill the low leaves, the identity fills the rest
    always_comb begin
        for (int k = 0; k < LEAVES; k++) begin
            leaves_o[k*W +: W] = (k < N) ? data_i[((k < N) ? k : 0)*W +: W] : ident_i;
        end
    end
endmodule

// File: rtl/par_reduce.sv
module par_reduce #(
    parameter int W = 8,
    parameter int N = 13,
    parameter par_reduce_pkg::op_e OP = par_reduce_pkg::OP_ADD
) (
    input  logic [N*W-1:0] data_i,
    input  logic [W-1:0]   ident_i,
    output logic [W-1:0]   result_o
);
    localparam int DEPTH  = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << DEPTH;

    logic [LEAVES*W-1:0] leaves;

    reduce_pad #(.W(W), .N(N), .LEAVES(LEAVES)) u_pad (
        .data_i   (data_i),
        .ident_i  (ident_i),
        .leaves_o (leaves)
    );

    // level d holds 2^d values; level DEPTH is the leaves, level 0 the root
    generate
        for (genvar d = 0; d <= DEPTH; d++) begin : g_lvl
            logic [(1<<d)*W-1:0] v;
            if (d == DEPTH) begin : g_leaf
                assign v = leaves;
            end else begin : g_inner
                for (genvar j = 0; j < (1 << d); j++) begin : g_node
                    reduce_node #(.W(W), .OP(OP)) u_node (
                        .a_i (g_lvl[d+1].v[(2*j)*W +: W]),
                        .b_i (g_lvl[d+1].v[(2*j+1)*W +: W]),
                        .y_o (v[j*W +: W])
                    );
                end
            end
        end
    endgenerate

    assign result_o = g_lvl[0].v;
endmodule

// File: rtl/par_reduce_chk.sv
module par_reduce_chk #(
    parameter int W = 8,
    parameter int N = 13,
    parameter par_reduce_pkg::op_e OP = par_reduce_pkg::OP_ADD
) (
    input logic [N*W-1:0] data_i,
    input logic [W-1:0]   ident_i,
    input logic [W-1:0]   result_o
);
    import par_reduce_pkg::*;
    localparam int DEPTH  = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << DEPTH;

    always_comb begin
        if (!$isunknown({data_i, ident_i, result_o})) begin
            if (N == 1) begin
                assert_passthru_R7: assert (result_o == data_i[W-1:0]);
            end
            for (int k = 0; k < N; k++) begin
                if (OP == OP_MAX) begin
                    assert_max_bound_R3: assert (result_o >= data_i[k*W +: W]);
                end
                if (OP == OP_AND) begin
                    assert_and_subset_R4: assert ((result_o & ~data_i[k*W +: W]) == '0);
                end
                if (OP == OP_OR) begin
                    assert_or_cover_R5: assert ((data_i[k*W +: W] & ~result_o) == '0);
                end
            end
            if (LEAVES > N && OP == OP_MAX) begin
                assert_pad_max_R8: assert (result_o >= ident_i);
            end
            if (LEAVES > N && OP == OP_AND) begin
                assert_pad_and_R8: assert ((result_o & ~ident_i) == '0);
            end
        end
    end
endmodule

bind par_reduce par_reduce_chk #(.W(W), .N(N), .OP(OP)) u_chk (
    .data_i   (data_i),
    .ident_i  (ident_i),
    .result_o (result_o)
);

// File: tb/sim_par_reduce.sv
`timescale 1ns/1ps
module sim_par_reduce;
    import par_reduce_pkg::*;

    localparam int W = 8;
    localparam int NDUT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] src [13];
    logic [W-1:0] id  [NDUT];

    logic [13*W-1:0] d0, d5;
    logic [1*W-1:0]  d1;
    logic [3*W-1:0]  d2;
    logic [5*W-1:0]  d3;
    logic [8*W-1:0]  d4;
    logic [W-1:0]    r [NDUT];

    par_reduce #(.W(W), .N(13), .OP(OP_ADD)) u0 (.data_i(d0), .ident_i(id[0]), .result_o(r[0]));
    par_reduce #(.W(W), .N(1),  .OP(OP_XOR)) u1 (.data_i(d1), .ident_i(id[1]), .result_o(r[1]));
    par_reduce #(.W(W), .N(3),  .OP(OP_MAX)) u2 (.data_i(d2), .ident_i(id[2]), .result_o(r[2]));
    par_reduce #(.W(W), .N(5),  .OP(OP_AND)) u3 (.data_i(d3), .ident_i(id[3]), .result_o(r[3]));
    par_reduce #(.W(W), .N(8),  .OP(OP_OR))  u4 (.data_i(d4), .ident_i(id[4]), .result_o(r[4]));
    par_reduce #(.W(W), .N(13), .OP(OP_XOR)) u5 (.data_i(d5), .ident_i(id[5]), .result_o(r[5]));

    typedef struct {
        int           dut;
        logic [W-1:0] exp;
        string        req;
    } item_t;
    item_t q[$];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam int  DN [NDUT] = '{13, 1, 3, 5, 8, 13};
    localparam op_e DO [NDUT] = '{OP_ADD, OP_XOR, OP_MAX, OP_AND, OP_OR, OP_XOR};

    function automatic logic [W-1:0] f2(op_e op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_MAX:  return (a > b) ? a : b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

    // left fold over n elements, then the padding leaves (R8)
    function automatic logic [W-1:0] ref_fold(op_e op, int n, logic [W-1:0] idv);
        logic [W-1:0] acc;
        int p2;
        acc = src[0];
        for (int k = 1; k < n; k++) acc = f2(op, acc, src[k]);
        p2 = 1;
        while (p2 < n) p2 = p2 * 2;
        for (int k = 0; k < p2 - n; k++) acc = f2(op, acc, idv);
        return acc;
    endfunction

    function automatic string tag(int dut, bit rnd_id);
        case (dut)
            0: return rnd_id ? "R8 R10" : "R2";
            1: return "R7";
            2: return rnd_id ? "R8" : "R3";
            3: return rnd_id ? "R8" : "R4";
            4: return rnd_id ? "R9" : "R5";
            default: return rnd_id ? "R8" : "R6";
        endcase
    endfunction

    task automatic pack_inputs();
        for (int k = 0; k < 13; k++) begin
            d0[k*W +: W] = src[k];
            d5[k*W +: W] = src[k];
            if (k < 1) d1[k*W +: W] = src[k];
            if (k < 3) d2[k*W +: W] = src[k];
            if (k < 5) d3[k*W +: W] = src[k];
            if (k < 8) d4[k*W +: W] = src[k];
        end
    endtask

    // driver: apply one pattern and queue the expected results
    task automatic step(bit rnd_id);
        item_t it;
        @(negedge clk);
        for (int i = 0; i < NDUT; i++) begin
            if (rnd_id) id[i] = W'($urandom);
            else        id[i] = (DO[i] == OP_AND) ? '1 : '0;
        end
        pack_inputs();
        for (int i = 0; i < NDUT; i++) begin
            it.dut = i;
            it.exp = ref_fold(DO[i], DN[i], id[i]);
            it.req = tag(i, rnd_id);
            q.push_back(it);
        end
    endtask

    // monitor: compare after each rising edge, away from the edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                it = q.pop_front();
                n_chk++;
                if (r[it.dut] !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s u%0d actual=%h expected=%h", it.req, it.dut, r[it.dut], it.exp);
                end
            end
        end
    end

    initial begin
        item_t it;
        for (int k = 0; k < 13; k++) src[k] = '0;
        for (int i = 0; i < NDUT; i++) id[i] = '0;
        pack_inputs();
        // zero inputs during reset: every shape gives zero
        repeat (3) begin
            @(negedge clk);
            for (int i = 0; i < NDUT; i++) begin
                it.dut = i; it.exp = '0; it.req = "R2";
                q.push_back(it);
            end
        end
        rst_n = 1'b1;
        // all ones
        for (int k = 0; k < 13; k++) src[k] = '1;
        step(0);
        step(1);
        // single set element walking across positions (R10)
        for (int p = 0; p < 13; p++) begin
            for (int k = 0; k < 13; k++) src[k] = (k == p) ? W'(8'h80 >> (p % 8)) : '0;
            step(0);
        end
        // random data, correct and random identity
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < 13; k++) src[k] = W'($urandom);
            step(t[0]);
        end
        @(posedge clk);
        #2;
        // R1: mid-cycle change, no clock edge in between
        for (int k = 0; k < 13; k++) src[k] = W'(k * 7 + 3);
        for (int i = 0; i < NDUT; i++) id[i] = (DO[i] == OP_AND) ? '1 : '0;
        pack_inputs();
        #0.2;
        n_chk++;
        if (r[0] !== ref_fold(OP_ADD, 13, '0)) begin
            n_bad++;
            $display("FAIL R1 u0 actual=%h expected=%h", r[0], ref_fold(OP_ADD, 13, '0));
        end
        n_chk++;
        if (r[2] !== ref_fold(OP_MAX, 3, '0)) begin
            n_bad++;
            $display("FAIL R1 u2 actual=%h expected=%h", r[2], ref_fold(OP_MAX, 3, '0));
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule